// File: doc/BRIEF.md
# Corrected-Data Write-Back Queue

This block sits beside an error-protected memory array and removes single-bit soft errors from it. The decoder or a background scrubber passes in entries made of an address and the corrected, re-encoded word. The queue holds them and writes them back into the array only in cycles when regular traffic leaves the write port free. Write-back therefore never costs a regular access a cycle, and a flipped bit is normally repaired before a second upset can land in the same block.

Corrections drain oldest first. A pending correction is dropped the moment a regular write targets its address, so a stale corrected word can never overwrite newer data. A `full` flag tells producers to pause. The scrubber must hold off while it is high, and any correction offered anyway is discarded and counted. A parameter selects dual-ported or single-ported memory. With a single port, a regular read also blocks write-back. A queue depth of zero removes the feature entirely.

Top module: `corr_wb_buf`

## Requirements
- R1: After reset the queue is empty: `wb_en`, `wb_done` and `full` are 0 and `drop_cnt` is 0.
- R2: With dual-ported memory, a write-back request (`wb_en`=1) is raised only in a cycle with `wr_en`=0. A concurrent regular read (`rd_en`=1) does not hold it back.
- R3: With single-ported memory (SINGLE_PORT=1), a write-back request is raised only in a cycle with both `wr_en`=0 and `rd_en`=0.
- R4: Buffered entries are written back oldest first. Each request presents the stored address on `wb_addr` and the stored word on `wb_word`.
- R5: A regular write (`wr_en`=1) whose `wr_addr` equals a buffered entry's address removes that entry, which is never written back. Other entries keep their order.
- R6: If `in_valid` and a regular write to the same address occur in one cycle, the offered entry is not stored.
- R7: `full` is 1 in the cycle after DEPTH live entries are held. It returns to 0 in the cycle after a write-back frees a slot.
- R8: An entry offered while `full`=1 is discarded, and `drop_cnt` increments by one per discarded entry. It saturates at all ones.
- R9: `wb_done` pulses to 1 exactly one cycle after each cycle with `wb_en`=1.
- R10: With DEPTH=0, `wb_en`, `full` and `drop_cnt` stay 0 whatever the inputs.
- R11: An entry accepted in a cycle can be requested for write-back no earlier than the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A corrected entry is offered this cycle |
| in_addr | input | ADDR_W | Target address of the offered entry |
| in_word | input | WORD_W | Corrected encoded word of the offered entry |
| rd_en | input | 1 | A regular read uses the memory this cycle |
| wr_en | input | 1 | A regular write uses the memory this cycle |
| wr_addr | input | ADDR_W | Address of the regular write |
| wb_en | output | 1 | Write-back request to the array's write port |
| wb_addr | output | ADDR_W | Write-back address |
| wb_word | output | WORD_W | Write-back data |
| wb_done | output | 1 | One-cycle pulse after each write-back |
| full | output | 1 | No free slot; producers must pause |
| drop_cnt | output | CNT_W | Saturating count of entries discarded while full |

## Verification
Three entries are loaded while a regular write holds the port, then released with the port idle. This separates true oldest-first draining from any other order and exposes a completion pulse that is missing or shifted. Concurrent reads are applied to a dual-ported and a single-ported instance side by side, which shows that only the single-ported variant yields to reads. A write to the middle entry's address distinguishes selective invalidation from flushing or leaving it in place, and a same-cycle offer and write to one address tests the collision rule. The queue is filled past capacity to check the full timing, the drop count and its saturation, and a depth-zero instance is driven to confirm it stays inert.

// File: rtl/cwb_pkg.sv
package cwb_pkg;
   // Width of a counter able to hold the values 0..n.
   function automatic int occ_bits(input int n);
      return (n < 1) ? 1 : $clog2(n + 1);
   endfunction
endpackage

// File: rtl/cwb_hit_vec.sv
module cwb_hit_vec #(
   parameter int ADDR_W = 10,
   parameter int DEPTH  = 2
) (
   input  logic [DEPTH-1:0]        valid,
   input  logic [DEPTH*ADDR_W-1:0] addr_flat,
   input  logic                    wr_en,
   input  logic [ADDR_W-1:0]       wr_addr,
   output logic [DEPTH-1:0]        hit
);
   for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
      assign hit[g] = valid[g] && wr_en && (addr_flat[g*ADDR_W +: ADDR_W] == wr_addr);
   end
endmodule

// File: rtl/cwb_port_arb.sv
module cwb_port_arb #(
   parameter bit SINGLE_PORT = 1'b0
) (
   input  logic head_valid,
   input  logic rd_en,
   input  logic wr_en,
   output logic grant
);
   if (SINGLE_PORT) begin : g_single
      assign grant = head_valid && !wr_en && !rd_en;
   end else begin : g_dual
      logic unused_rd;
      assign unused_rd = rd_en;
      assign grant     = head_valid && !wr_en;
   end
endmodule

// File: rtl/cwb_sat_ctr.sv
module cwb_sat_ctr #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   output logic [CNT_W-1:0] count
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    count <= '0;
      else if (inc && (count != '1)) count <= count + 1'b1;
   end
endmodule

// File: rtl/corr_wb_buf.sv
module corr_wb_buf #(
   parameter int ADDR_W      = 10,
   parameter int WORD_W      = 39,
   parameter int DEPTH       = 2,
   parameter bit SINGLE_PORT = 1'b0,
   parameter int CNT_W       = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [ADDR_W-1:0] in_addr,
   input  logic [WORD_W-1:0] in_word,
   input  logic              rd_en,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   output logic              wb_en,
   output logic [ADDR_W-1:0] wb_addr,
   output logic [WORD_W-1:0] wb_word,
   output logic              wb_done,
   output logic              full,
   output logic [CNT_W-1:0]  drop_cnt
);
   localparam int OCC_W = cwb_pkg::occ_bits(DEPTH);

   initial begin
      assert (ADDR_W > 0 && WORD_W > 0 && CNT_W > 0 && DEPTH >= 0)
         else $error("corr_wb_buf: illegal parameter set");
   end

   if (DEPTH == 0) begin : g_off
      logic unused_in;
      assign unused_in = ^{clk, rst_n, in_valid, in_addr, in_word, rd_en, wr_en, wr_addr};
      assign wb_en    = 1'b0;
      assign wb_addr  = '0;
      assign wb_word  = '0;
      assign wb_done  = 1'b0;
      assign full     = 1'b0;
      assign drop_cnt = '0;
   end else begin : g_on
      // Live entries are kept packed at slots 0..n-1, slot 0 oldest.
      logic [DEPTH-1:0]        vld_q, vld_d, hit, keep;
      logic [ADDR_W-1:0]       addr_q [DEPTH];
      logic [ADDR_W-1:0]       addr_d [DEPTH];
      logic [WORD_W-1:0]       word_q [DEPTH];
      logic [WORD_W-1:0]       word_d [DEPTH];
      logic [DEPTH*ADDR_W-1:0] addr_flat;
      logic                    grant, collide, accept, full_q, done_q;
      logic [OCC_W-1:0]        live_n;

      for (genvar g = 0; g < DEPTH; g++) begin : g_pack
         assign addr_flat[g*ADDR_W +: ADDR_W] = addr_q[g];
      end

      cwb_hit_vec #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_hit (
         .valid(vld_q), .addr_flat(addr_flat), .wr_en(wr_en),
         .wr_addr(wr_addr), .hit(hit)
      );

      cwb_port_arb #(.SINGLE_PORT(SINGLE_PORT)) u_arb (
         .head_valid(vld_q[0]), .rd_en(rd_en), .wr_en(wr_en), .grant(grant)
      );

      assign collide = wr_en && (wr_addr == in_addr);
      assign accept  = in_valid && !full_q && !collide;

      always_comb begin
         keep = vld_q & ~hit;
         if (grant) keep[0] = 1'b0;
         vld_d  = '0;
         live_n = '0;
         for (int i = 0; i < DEPTH; i++) begin
            addr_d[i] = addr_q[i];
            word_d[i] = word_q[i];
         end
         for (int i = 0; i < DEPTH; i++) begin
            if (keep[i]) begin
               addr_d[live_n] = addr_q[i];
               word_d[live_n] = word_q[i];
               vld_d[live_n]  = 1'b1;
               live_n         = live_n + 1'b1;
            end
         end
         if (accept && (int'(live_n) < DEPTH)) begin
            addr_d[live_n] = in_addr;
            word_d[live_n] = in_word;
            vld_d[live_n]  = 1'b1;
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vld_q  <= '0;
            full_q <= 1'b0;
            done_q <= 1'b0;
         end else begin
            vld_q  <= vld_d;
            full_q <= vld_d[DEPTH-1];
            done_q <= grant;
         end
      end

      always_ff @(posedge clk) begin
         for (int i = 0; i < DEPTH; i++) begin
            addr_q[i] <= addr_d[i];
            word_q[i] <= word_d[i];
         end
      end

      cwb_sat_ctr #(.CNT_W(CNT_W)) u_drop (
         .clk(clk), .rst_n(rst_n), .inc(in_valid && full_q), .count(drop_cnt)
      );

      assign wb_en   = grant;
      assign wb_addr = addr_q[0];
      assign wb_word = word_q[0];
      assign wb_done = done_q;
      assign full    = full_q;
   end
endmodule

// File: rtl/cwb_checker.sv
module cwb_checker #(
   parameter bit SINGLE_PORT = 1'b0,
   parameter int CNT_W       = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic             rd_en,
   input logic             wr_en,
   input logic             wb_en,
   input logic             wb_done,
   input logic             full,
   input logic [CNT_W-1:0] drop_cnt
);
   // R2
   wb_vs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wb_en |-> !wr_en);

   // R3
   wb_vs_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (SINGLE_PORT && wb_en) |-> !rd_en);

   // R9
   done_after_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wb_en |=> wb_done);

   // R9
   done_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wb_done |-> $past(wb_en));

   // R7
   full_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(full) |-> $past(in_valid));

   // R8
   drop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && full && drop_cnt != '1) |=> drop_cnt == CNT_W'($past(drop_cnt) + 1'b1));
endmodule

bind corr_wb_buf cwb_checker #(.SINGLE_PORT(SINGLE_PORT), .CNT_W(CNT_W)) u_cwb_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .rd_en(rd_en), .wr_en(wr_en),
   .wb_en(wb_en), .wb_done(wb_done), .full(full), .drop_cnt(drop_cnt)
);

// File: tb/tb_corr_wb_buf.sv
module tb_corr_wb_buf;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 8;
   localparam int WW = 16;
   localparam int CW = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0, rd_en = 1'b0, wr_en = 1'b0;
   logic [AW-1:0] in_addr = '0, wr_addr = '0;
   logic [WW-1:0] in_word;

   logic wb_en, wb_done, full;
   logic [AW-1:0] wb_addr;
   logic [WW-1:0] wb_word;
   logic [CW-1:0] drop_cnt;
   logic sp_en, sp_done, sp_full;
   logic [AW-1:0] sp_addr;
   logic [WW-1:0] sp_word;
   logic [CW-1:0] sp_drop;
   logic z_en, z_done, z_full;
   logic [AW-1:0] z_addr;
   logic [WW-1:0] z_word;
   logic [CW-1:0] z_drop;

   int n_chk = 0;
   int n_err = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [WW-1:0] wf(input logic [AW-1:0] a);
      return {~a, a};
   endfunction
   assign in_word = wf(in_addr);

   corr_wb_buf #(.ADDR_W(AW), .WORD_W(WW), .DEPTH(4), .SINGLE_PORT(1'b0), .CNT_W(CW)) dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_addr(in_addr), .in_word(in_word),
      .rd_en(rd_en), .wr_en(wr_en), .wr_addr(wr_addr), .wb_en(wb_en), .wb_addr(wb_addr),
      .wb_word(wb_word), .wb_done(wb_done), .full(full), .drop_cnt(drop_cnt));

   corr_wb_buf #(.ADDR_W(AW), .WORD_W(WW), .DEPTH(2), .SINGLE_PORT(1'b1), .CNT_W(CW)) dut_sp (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_addr(in_addr), .in_word(in_word),
      .rd_en(rd_en), .wr_en(wr_en), .wr_addr(wr_addr), .wb_en(sp_en), .wb_addr(sp_addr),
      .wb_word(sp_word), .wb_done(sp_done), .full(sp_full), .drop_cnt(sp_drop));

   corr_wb_buf #(.ADDR_W(AW), .WORD_W(WW), .DEPTH(0), .SINGLE_PORT(1'b0), .CNT_W(CW)) dut_off (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_addr(in_addr), .in_word(in_word),
      .rd_en(rd_en), .wr_en(wr_en), .wr_addr(wr_addr), .wb_en(z_en), .wb_addr(z_addr),
      .wb_word(z_word), .wb_done(z_done), .full(z_full), .drop_cnt(z_drop));

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // One cycle: inputs applied after the falling edge, outputs readable on return.
   task automatic cyc(input logic iv, input logic [AW-1:0] ia, input logic we,
                      input logic [AW-1:0] wa, input logic re);
      @(negedge clk);
      in_valid = iv; in_addr = ia; wr_en = we; wr_addr = wa; rd_en = re;
      #1;
   endtask

   task automatic idle();
      cyc(1'b0, '0, 1'b0, '0, 1'b0);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; in_valid = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic t_reset();
      do_reset();
      idle();
      chk("R1 wb_en",    32'(wb_en),    0);
      chk("R1 wb_done",  32'(wb_done),  0);
      chk("R1 full",     32'(full),     0);
      chk("R1 drop_cnt", 32'(drop_cnt), 0);
   endtask

   task automatic t_order();
      do_reset();
      cyc(1'b1, 8'h21, 1'b1, 8'hFF, 1'b0); chk("R2 held by write", 32'(wb_en), 0);
      cyc(1'b1, 8'h42, 1'b1, 8'hFF, 1'b0); chk("R2 held by write", 32'(wb_en), 0);
      cyc(1'b1, 8'h63, 1'b1, 8'hFF, 1'b0);
      idle();
      chk("R4 first en", 32'(wb_en), 1);   chk("R4 first addr", 32'(wb_addr), 32'h21);
      chk("R4 first word", 32'(wb_word), 32'(wf(8'h21)));
      chk("R9 no done yet", 32'(wb_done), 0);
      idle();
      chk("R4 second addr", 32'(wb_addr), 32'h42); chk("R9 done", 32'(wb_done), 1);
      idle();
      chk("R4 third addr", 32'(wb_addr), 32'h63);
      chk("R4 third word", 32'(wb_word), 32'(wf(8'h63)));
      idle();
      chk("R4 drained", 32'(wb_en), 0);    chk("R9 last done", 32'(wb_done), 1);
      idle();
      chk("R9 done ends", 32'(wb_done), 0);
   endtask

   task automatic t_latency();
      do_reset();
      cyc(1'b1, 8'h5A, 1'b0, 8'h00, 1'b0);
      chk("R11 no same-cycle wb", 32'(wb_en), 0);
      idle();
      chk("R11 next-cycle wb", 32'(wb_en), 1);
      chk("R11 addr", 32'(wb_addr), 32'h5A);
   endtask

   task automatic t_read_port();
      do_reset();
      cyc(1'b1, 8'h11, 1'b0, 8'h00, 1'b1);
      cyc(1'b0, 8'h00, 1'b0, 8'h00, 1'b1);
      chk("R2 dual ignores read", 32'(wb_en), 1);
      chk("R2 dual addr", 32'(wb_addr), 32'h11);
      chk("R3 single held by read", 32'(sp_en), 0);
      idle();
      chk("R3 single after read", 32'(sp_en), 1);
      chk("R3 single addr", 32'(sp_addr), 32'h11);
      chk("R2 dual drained", 32'(wb_en), 0);
   endtask

   task automatic t_invalidate();
      do_reset();
      cyc(1'b1, 8'h10, 1'b1, 8'h99, 1'b0);
      cyc(1'b1, 8'h20, 1'b1, 8'h99, 1'b0);
      cyc(1'b1, 8'h30, 1'b1, 8'h99, 1'b0);
      cyc(1'b0, 8'h00, 1'b1, 8'h20, 1'b0);
      chk("R5 write cycle no wb", 32'(wb_en), 0);
      idle();
      chk("R5 head addr", 32'(wb_addr), 32'h10);
      idle();
      chk("R5 skipped hit", 32'(wb_addr), 32'h30);
      chk("R5 en", 32'(wb_en), 1);
      idle();
      chk("R5 empty", 32'(wb_en), 0);
   endtask

   task automatic t_collide();
      do_reset();
      cyc(1'b1, 8'h44, 1'b1, 8'h44, 1'b0);
      idle();
      chk("R6 not stored", 32'(wb_en), 0);
      chk("R6 full", 32'(full), 0);
   endtask

   task automatic t_full();
      do_reset();
      for (int i = 0; i < 3; i++) cyc(1'b1, 8'(8'h70 + i), 1'b1, 8'hFE, 1'b0);
      chk("R7 three not full", 32'(full), 0);
      cyc(1'b1, 8'h73, 1'b1, 8'hFE, 1'b0);
      chk("R7 before edge", 32'(full), 0);
      cyc(1'b1, 8'hE0, 1'b1, 8'hFE, 1'b0);
      chk("R7 full", 32'(full), 1);
      cyc(1'b1, 8'hE1, 1'b1, 8'hFE, 1'b0);
      chk("R8 one drop", 32'(drop_cnt), 1);
      idle();
      chk("R8 two drops", 32'(drop_cnt), 2);
      chk("R7 drain starts", 32'(wb_addr), 32'h70);
      for (int i = 1; i < 4; i++) begin
         idle();
         if (i == 1) chk("R7 full clears", 32'(full), 0);
         chk("R8 dropped not kept", 32'(wb_addr), 32'(8'h70 + i));
      end
      idle();
      chk("R8 nothing extra", 32'(wb_en), 0);
   endtask

   task automatic t_saturate();
      do_reset();
      for (int i = 0; i < 4; i++) cyc(1'b1, 8'(8'h80 + i), 1'b1, 8'hFE, 1'b0);
      for (int i = 0; i < 10; i++) cyc(1'b1, 8'hC0, 1'b1, 8'hFE, 1'b0);
      idle();
      chk("R8 saturates", 32'(drop_cnt), 7);
   endtask

   task automatic t_off();
      do_reset();
      for (int i = 0; i < 6; i++) begin
         cyc(1'b1, 8'(i), 1'b0, 8'hAA, 1'b0);
         chk("R10 no wb", 32'(z_en), 0);
      end
      idle();
      chk("R10 no full", 32'(z_full), 0);
      chk("R10 no drops", 32'(z_drop), 0);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      t_reset();
      t_order();
      t_latency();
      t_read_port();
      t_invalidate();
      t_collide();
      t_full();
      t_saturate();
      t_off();
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule